// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block runs a binary search that digitizes an unsigned target level of `WIDTH` bits (eight by default). A one-cycle start pulse makes it clear its running estimate and its decision array. It then spends one cycle loading a bit-weight register and `WIDTH` test cycles that go from the most significant weight down to weight one. In each test cycle it adds the current weight to the best estimate so far, drives that trial value out as the DAC code, and compares it with the target using an internal digital comparator. The bit is kept when the trial does not exceed the target.

The bit weight comes from a register that is loaded with `2**WIDTH` and halved on every cycle of the conversion. This is why a load cycle comes before the first test. Each decision is also written into a separate bit array, at the position of the test-cycle index, so the partial result is visible while the conversion runs. Every conversion takes the same number of cycles, whatever the input level. A start pulse that arrives during a conversion has no effect.

Top module: `succ_approx_ctrl`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are 0, and `bestEst`, `bitArray` and `dacDrive` are all zero.
- R2: A start pulse taken while idle clears `bestEst` and `bitArray` to zero at the next clock edge, and `busy` rises at that same edge.
- R3: One load cycle comes after the start edge, followed by `WIDTH` test cycles. In test cycle k (k = 0 first) the weight is 2^(WIDTH-1-k), and `dacDrive` shows the trial value, which is `bestEst` plus that weight. With WIDTH=8 the weights are 128, 64, 32, 16, 8, 4, 2, 1.
- R4: A trial value greater than `targetLevel` drops the bit and leaves `bestEst` unchanged. A trial value less than or equal to `targetLevel` keeps the bit, and `bestEst` becomes the trial value. As a result, an input of 255 converts to 0xFF and an input of 0 converts to 0x00.
- R5: The decision of test cycle k is written into `bitArray[k]` at the end of that cycle. Element k therefore holds result bit WIDTH-1-k, and element 0 holds the MSB decision.
- R6: `done` is high for exactly one clock. It rises at the ninth clock edge after the start edge (WIDTH+1 edges in general), and `busy` falls at that same edge. The count does not depend on the input level.
- R7: A start pulse taken while `busy` is high is ignored. It does not change the result or the timing of `done`.
- R8: Once `done` has been seen, `bestEst` and `bitArray` hold their values until the next accepted start, and `bitArray` equals `bestEst` with its bits reversed.
- R9: For an input of 153, the first four trial values are 128 (kept), 192 (dropped), 160 (dropped) and 144 (kept), and the final result is 8'b10011001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Starts a conversion when the block is idle |
| targetLevel | input | WIDTH | Level to digitize; held steady during a conversion |
| dacDrive | output | WIDTH | Trial value during test cycles; otherwise the best estimate |
| bestEst | output | WIDTH | Running and final best estimate |
| bitArray | output | WIDTH | Decision array; element k is the decision of test cycle k |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle strobe when the last decision is registered |

## Verification
The bench counts clock edges from the edge that takes the start pulse. It expects `busy` and the cleared state one edge later, the first trial on `dacDrive` after the second edge, and each later trial one edge after the one before it. The decision for test k shows up in `bitArray[k]` one edge after that trial is driven, and `done` is expected after edge WIDTH+1 and nowhere else. Every sample is taken on the falling clock edge that follows the counted rising edge, and the expected trials and bits come from a bench model of the halving search. The bench also applies a start pulse in the middle of a conversion and holds the block idle for a while after `done`, so that R7 and R8 are checked at the ports.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_TEST = 2'd2
  } sarPhase_t;

  typedef struct packed {
    logic clearAll;
    logic halveWeight;
    logic testStep;
  } sarStrobes_t;

endpackage

// File: rtl/sar_control.sv
module sar_control #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  output sar_pkg::sarStrobes_t  strobes,
  output logic [IDX_W-1:0]      testIdx,
  output logic                  busy,
  output logic                  done
);
  import sar_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

  sarPhase_t phase, phaseNext;
  logic      acceptStart;
  logic      lastTest;

  assign acceptStart = startPulse && (phase == PH_IDLE);
  assign lastTest    = (phase == PH_TEST) && (testIdx == LAST_IDX);

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE: if (acceptStart) phaseNext = PH_LOAD;
      PH_LOAD: phaseNext = PH_TEST;
      PH_TEST: if (lastTest) phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    strobes             = '0;
    strobes.clearAll    = acceptStart;
    strobes.halveWeight = (phase == PH_LOAD) || (phase == PH_TEST);
    strobes.testStep    = (phase == PH_TEST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      testIdx <= '0;
      done    <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= lastTest;
      if (acceptStart) begin
        testIdx <= '0;
      end else if (strobes.testStep && !lastTest) begin
        testIdx <= testIdx + 1'b1;
      end
    end
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sar_pkg::sarStrobes_t  strobes,
  input  logic [IDX_W-1:0]      testIdx,
  input  logic [WIDTH-1:0]      targetLevel,
  output logic [WIDTH-1:0]      dacDrive,
  output logic [WIDTH-1:0]      bestEst,
  output logic [WIDTH-1:0]      bitArray
);

  localparam logic [WIDTH:0] WEIGHT_INIT = (WIDTH+1)'(1) << WIDTH;

  logic [WIDTH:0]   weightReg;
  logic [WIDTH-1:0] trialVal;
  logic             keepBit;

  assign trialVal = bestEst + weightReg[WIDTH-1:0];
  assign keepBit  = (trialVal <= targetLevel);
  assign dacDrive = strobes.testStep ? trialVal : bestEst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weightReg <= '0;
      bestEst   <= '0;
    end else if (strobes.clearAll) begin
      weightReg <= WEIGHT_INIT;
      bestEst   <= '0;
    end else begin
      if (strobes.halveWeight) weightReg <= weightReg >> 1;
      if (strobes.testStep && keepBit) bestEst <= trialVal;
    end
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitArray[k] <= 1'b0;
      end else if (strobes.clearAll) begin
        bitArray[k] <= 1'b0;
      end else if (strobes.testStep && (testIdx == IDX_W'(k))) begin
        bitArray[k] <= keepBit;
      end
    end
  end

endmodule

// File: rtl/succ_approx_ctrl.sv
module succ_approx_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [WIDTH-1:0] targetLevel,
  output logic [WIDTH-1:0] dacDrive,
  output logic [WIDTH-1:0] bestEst,
  output logic [WIDTH-1:0] bitArray,
  output logic             busy,
  output logic             done
);

  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  sar_pkg::sarStrobes_t strobes;
  logic [IDX_W-1:0]     testIdx;

  sar_control #(.WIDTH(WIDTH)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .strobes    (strobes),
    .testIdx    (testIdx),
    .busy       (busy),
    .done       (done)
  );

  sar_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .testIdx     (testIdx),
    .targetLevel (targetLevel),
    .dacDrive    (dacDrive),
    .bestEst     (bestEst),
    .bitArray    (bitArray)
  );

endmodule

// File: rtl/succ_approx_ctrl_checker.sv
module succ_approx_ctrl_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [WIDTH-1:0] dacDrive,
  input logic [WIDTH-1:0] bestEst,
  input logic [WIDTH-1:0] bitArray,
  input logic             busy,
  input logic             done
);

  localparam int CNT_W = $clog2(WIDTH + 4);
  localparam logic [CNT_W-1:0] DONE_AT = CNT_W'(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIDTH + 3);

  logic [CNT_W-1:0] sinceStart;
  logic [WIDTH-1:0] bestRev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceStart <= CNT_MAX;
    else if (startPulse && !busy) sinceStart <= '0;
    else if (sinceStart != CNT_MAX) sinceStart <= sinceStart + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) bestRev[i] = bestEst[WIDTH-1-i];
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceStart == DONE_AT)); // R7

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R6

  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> (dacDrive == (WIDTH'(1) << (WIDTH-1)))); // R3

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy) |=> (bestEst == '0 && bitArray == '0 && busy)); // R2

  AST_ARRAY_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (bitArray == bestRev)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> ($stable(bestEst) && $stable(bitArray))); // R8

endmodule

bind succ_approx_ctrl succ_approx_ctrl_checker #(.WIDTH(WIDTH)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .dacDrive   (dacDrive),
  .bestEst    (bestEst),
  .bitArray   (bitArray),
  .busy       (busy),
  .done       (done)
);

// File: tb/succ_approx_ctrl_test.sv
module succ_approx_ctrl_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startPulse = 1'b0;
  logic [W-1:0] targetLevel = '0;
  logic [W-1:0] dacDrive, bestEst, bitArray;
  logic         busy, done;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  succ_approx_ctrl #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .targetLevel(targetLevel),
    .dacDrive(dacDrive), .bestEst(bestEst), .bitArray(bitArray),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expTrial(input int level, input int k);
    int best = 0;
    for (int j = 0; j < k; j++) begin
      int t = best + (1 << (W - 1 - j));
      if (t <= level) best = t;
    end
    return best + (1 << (W - 1 - k));
  endfunction

  function automatic int expBit(input int level, input int k);
    return (expTrial(level, k) <= level) ? 1 : 0;
  endfunction

  // One conversion; startAgainAt >= 0 pulses start during that test cycle.
  task automatic convert(input int level, input int startAgainAt);
    targetLevel = W'(level);
    startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0;
    check("R2", "busy after start", int'(busy), 1);
    check("R2", "cleared estimate", int'(bestEst), 0);
    check("R2", "cleared array", int'(bitArray), 0);
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < W; k++) begin
      check("R3", $sformatf("trial %0d", k), int'(dacDrive), expTrial(level, k));
      check("R6", "done early", int'(done), 0);
      if (k == startAgainAt) startPulse = 1'b1;
      @(posedge clk);
      @(negedge clk);
      startPulse = 1'b0;
      check("R5", $sformatf("array slot %0d", k), int'(bitArray[k]), expBit(level, k));
    end
    check("R6", "done strobe", int'(done), 1);
    check("R6", "busy low at done", int'(busy), 0);
    check("R4", "result", int'(bestEst), level);
    for (int i = 0; i < W; i++)
      check("R8", "array vs result", int'(bitArray[i]), int'(bestEst[W-1-i]));
    @(posedge clk);
    @(negedge clk);
    check("R6", "done single cycle", int'(done), 0);
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check("R1", "busy at reset", int'(busy), 0);
    check("R1", "done at reset", int'(done), 0);
    check("R1", "estimate at reset", int'(bestEst), 0);
    check("R1", "array at reset", int'(bitArray), 0);
    check("R1", "dac at reset", int'(dacDrive), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9 worked example
    check("R9", "trial 0", expTrial(153, 0), 128);
    convert(153, -1);
    check("R9", "final 153", int'(bestEst), 8'b10011001);

    convert(255, -1);   // R4 equality keeps
    check("R4", "full scale", int'(bestEst), 255);
    convert(0, -1);
    check("R4", "zero", int'(bestEst), 0);
    convert(128, -1);
    convert(127, -1);
    convert(1, -1);

    // R7 start during conversion
    convert(77, 3);
    check("R7", "result after ignored start", int'(bestEst), 77);
    convert(200, 0);
    convert(9, W - 1);

    // R8 hold while idle, target changed
    targetLevel = 8'h11;
    repeat (5) @(negedge clk);
    check("R8", "held estimate", int'(bestEst), 9);
    check("R8", "held busy", int'(busy), 0);

    for (int n = 0; n < 40; n++) begin
      int lvl = int'($urandom_range(0, 255));
      int again = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, W - 1)) : -1;
      convert(lvl, again);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule